// File: doc/BRIEF.md
# Configuration bitstream header parser

This block sits on a byte stream that carries several configuration images woven together. The stream is cut into fixed chunks of `CHUNK` bytes, and the chunks are taken from each image in turn. One byte is transferred per valid/ready handshake. After a start pulse the block counts every byte it accepts. It keeps only the bytes of the image picked by `img_sel` and silently swallows the rest.

The kept bytes are checked against a fixed 13-byte file preamble. The block then walks the tagged sections that follow. Each section is a one-letter tag, a big-endian length and that many content bytes. The walk stops when the tag named by `want_tag` is found, and the block reports that section's length. At that point the next kept byte, the first content byte of the section, is still waiting on the input, so a downstream consumer can take the payload straight from the same stream. The walk can also end with an error or with not-found.

`img_sel` and `want_tag` are latched on the start pulse. `done`, `found`, `err` and `sec_len` are registered. They hold until the next start pulse.

Top module: `cfg_hdr_walker`

## Requirements
- R1: After reset, and in the cycle after a start pulse, `done`, `found`, `err` and `sec_len` are all 0. Before the first start, `in_ready` is 0. A start pulse restarts a parse that is in progress, and `img_sel`/`want_tag` are captured on that pulse.
- R2: Accepted bytes are numbered from 0 at each start. Byte i belongs to image `(i / CHUNK) mod N_IMG`, and only bytes whose image equals the latched `img_sel` (0-based) are parsed. All other bytes are accepted and dropped.
- R3: The first 13 kept bytes must be 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. On the first kept byte that differs, the block ends with `done`=1, `err`=1, `found`=0 and accepts nothing further.
- R4: A tag byte outside 0x61..0x65 ('a'..'e') ends the walk with `done`=1, `found`=0, `err`=0.
- R5: Tag 0x65 is followed by a 4-byte length and every other tag by a 2-byte length, both most significant byte first.
- R6: A length above 255 under any tag other than 0x65 ends the walk with `done`=1, `err`=1, `found`=0, even when that tag is the requested one.
- R7: When the tag equals the latched `want_tag`, the block ends with `done`=1, `found`=1 and `sec_len` equal to the length. The byte after the last length byte is not consumed. `sec_len` is 0 whenever `found` is 0.
- R8: A section whose tag is not requested has its length's worth of content bytes dropped, and the next kept byte is read as a tag. A zero length moves straight to the next tag.
- R9: The bytes kept after the preamble are counted, covering tags, length bytes and skipped content. Once the count reaches `LIMIT` (100), no further tag is read and no further content is skipped, and the walk ends with `done`=1, `found`=0, `err`=0. A tag read while the count is below `LIMIT` still has its full length field read.
- R10: While `done`=1, `in_ready` is 0, and `found`, `err` and `sec_len` stay unchanged until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a new parse |
| img_sel | input | SEL_W | Image index to keep, 0-based, latched on start |
| want_tag | input | 8 | ASCII tag of the requested section, latched on start |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte is present |
| in_ready | output | 1 | Block accepts the byte this cycle |
| done | output | 1 | Parse finished |
| found | output | 1 | Requested section located |
| err | output | 1 | Preamble mismatch or oversize short length |
| sec_len | output | LEN_W | Length of the located section |

## Verification
Every result is decided by a byte and registered on the edge that accepts that byte. The result is therefore visible from the next falling edge, where the bench samples it. The exception is the search limit, which is decided in a cycle that consumes no kept byte, so it appears one cycle later. The bench drives the stream at falling edges. It counts a byte as consumed only when `in_ready` was high in the cycle that byte was presented. The number of raw stream bytes consumed by the time `done` rises is compared with a value derived from the kept-byte count and the chunk arithmetic, which shows where the stream was left. After `done`, further cycles with a byte offered confirm that nothing moves.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  typedef enum logic [2:0] {
    W_IDLE,
    W_PRE,
    W_TAG,
    W_LEN,
    W_SKIP,
    W_DONE
  } walk_st_t;

  localparam int          PRE_LEN  = 13;
  localparam int          PIDX_W   = 4;
  localparam logic [7:0]  TAG_LO   = 8'h61;
  localparam logic [7:0]  TAG_HI   = 8'h65;
  localparam logic [7:0]  TAG_WIDE = 8'h65;

  // Expected value of preamble byte number idx
  function automatic logic [7:0] pre_byte(input logic [PIDX_W-1:0] idx);
    logic [7:0] b;
    case (idx)
      4'd0:    b = 8'h00;
      4'd1:    b = 8'h09;
      4'd10:   b = 8'h00;
      4'd11:   b = 8'h00;
      4'd12:   b = 8'h01;
      default: b = idx[0] ? 8'hF0 : 8'h0F;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/hdr_lane_filter.sv
module hdr_lane_filter #(
  parameter int CHUNK = 288,
  parameter int N_IMG = 2,
  localparam int SEL_W = (N_IMG > 1) ? $clog2(N_IMG) : 1,
  localparam int OFF_W = (CHUNK > 1) ? $clog2(CHUNK) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  input  logic             take,
  output logic             lane_hit
);

  localparam logic [OFF_W-1:0] OFF_LAST  = OFF_W'(CHUNK - 1);
  localparam logic [SEL_W-1:0] LANE_LAST = SEL_W'(N_IMG - 1);

  logic [OFF_W-1:0] off_q;
  logic [SEL_W-1:0] lane_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= '0;
      lane_q <= '0;
      sel_q  <= '0;
    end else if (restart) begin
      off_q  <= '0;
      lane_q <= '0;
      sel_q  <= sel;
    end else if (take) begin
      if (off_q == OFF_LAST) begin
        off_q  <= '0;
        lane_q <= (lane_q == LANE_LAST) ? '0 : lane_q + 1'b1;
      end else begin
        off_q <= off_q + 1'b1;
      end
    end
  end

  assign lane_hit = (lane_q == sel_q);

endmodule

// File: rtl/hdr_preamble_cmp.sv
module hdr_preamble_cmp
  import cfg_hdr_pkg::*;
(
  input  logic [PIDX_W-1:0] idx,
  input  logic [7:0]        data,
  output logic              hit,
  output logic              last
);

  assign hit  = (data == pre_byte(idx));
  assign last = (idx == PIDX_W'(PRE_LEN - 1));

endmodule

// File: rtl/hdr_section_walker.sv
module hdr_section_walker
  import cfg_hdr_pkg::*;
#(
  parameter int LIMIT = 100,
  parameter int LEN_W = 32,
  localparam int CNT_W = $clog2(LIMIT + 8)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [7:0]       want_tag,
  input  logic             kv,
  input  logic [7:0]       kbyte,
  output logic             want_byte,
  output logic             busy,
  output logic             done_o,
  output logic             found_o,
  output logic             err_o,
  output logic [LEN_W-1:0] len_o
);

  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

  walk_st_t          st_q;
  logic [PIDX_W-1:0] pidx_q;
  logic [7:0]        want_q;
  logic [7:0]        tag_q;
  logic [LEN_W-1:0]  acc_q;
  logic [2:0]        nlen_q;
  logic [LEN_W-1:0]  rem_q;
  logic [CNT_W-1:0]  cnt_q;

  logic              pre_hit, pre_last;
  logic [LEN_W-1:0]  acc_nxt;
  logic              under_lim;
  logic              tag_ok;
  logic              too_long;

  hdr_preamble_cmp u_pre (
    .idx  (pidx_q),
    .data (kbyte),
    .hit  (pre_hit),
    .last (pre_last)
  );

  assign acc_nxt   = {acc_q[LEN_W-9:0], kbyte};
  assign under_lim = (cnt_q < LIM_C);
  assign tag_ok    = (kbyte >= TAG_LO) && (kbyte <= TAG_HI);
  assign too_long  = (tag_q != TAG_WIDE) && (|acc_nxt[LEN_W-1:8]);

  always_comb begin
    case (st_q)
      W_PRE, W_LEN:   want_byte = 1'b1;
      W_TAG, W_SKIP:  want_byte = under_lim;
      default:        want_byte = 1'b0;
    endcase
  end

  assign busy = (st_q == W_PRE) || (st_q == W_TAG) ||
                (st_q == W_LEN) || (st_q == W_SKIP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= W_IDLE;
      pidx_q  <= '0;
      want_q  <= '0;
      tag_q   <= '0;
      acc_q   <= '0;
      nlen_q  <= '0;
      rem_q   <= '0;
      cnt_q   <= '0;
      done_o  <= 1'b0;
      found_o <= 1'b0;
      err_o   <= 1'b0;
      len_o   <= '0;
    end else if (start) begin
      st_q    <= W_PRE;
      pidx_q  <= '0;
      want_q  <= want_tag;
      cnt_q   <= '0;
      done_o  <= 1'b0;
      found_o <= 1'b0;
      err_o   <= 1'b0;
      len_o   <= '0;
    end else begin
      case (st_q)
        W_PRE: if (kv) begin
          if (!pre_hit) begin
            st_q   <= W_DONE;
            done_o <= 1'b1;
            err_o  <= 1'b1;
          end else if (pre_last) begin
            st_q <= W_TAG;
          end else begin
            pidx_q <= pidx_q + 1'b1;
          end
        end
        W_TAG: begin
          if (!under_lim) begin
            st_q   <= W_DONE;
            done_o <= 1'b1;
          end else if (kv) begin
            cnt_q <= cnt_q + 1'b1;
            if (!tag_ok) begin
              st_q   <= W_DONE;
              done_o <= 1'b1;
            end else begin
              st_q   <= W_LEN;
              tag_q  <= kbyte;
              acc_q  <= '0;
              nlen_q <= (kbyte == TAG_WIDE) ? 3'd4 : 3'd2;
            end
          end
        end
        W_LEN: if (kv) begin
          cnt_q <= cnt_q + 1'b1;
          acc_q <= acc_nxt;
          if (nlen_q == 3'd1) begin
            if (too_long) begin
              st_q   <= W_DONE;
              done_o <= 1'b1;
              err_o  <= 1'b1;
            end else if (tag_q == want_q) begin
              st_q    <= W_DONE;
              done_o  <= 1'b1;
              found_o <= 1'b1;
              len_o   <= acc_nxt;
            end else if (acc_nxt == '0) begin
              st_q <= W_TAG;
            end else begin
              st_q  <= W_SKIP;
              rem_q <= acc_nxt;
            end
          end else begin
            nlen_q <= nlen_q - 1'b1;
          end
        end
        W_SKIP: begin
          if (!under_lim) begin
            st_q   <= W_DONE;
            done_o <= 1'b1;
          end else if (kv) begin
            cnt_q <= cnt_q + 1'b1;
            rem_q <= rem_q - 1'b1;
            if (rem_q == LEN_W'(1)) st_q <= W_TAG;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cfg_hdr_walker.sv
module cfg_hdr_walker #(
  parameter int CHUNK = 288,
  parameter int N_IMG = 2,
  parameter int LIMIT = 100,
  parameter int LEN_W = 32,
  localparam int SEL_W = (N_IMG > 1) ? $clog2(N_IMG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SEL_W-1:0] img_sel,
  input  logic [7:0]       want_tag,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             done,
  output logic             found,
  output logic             err,
  output logic [LEN_W-1:0] sec_len
);

  logic lane_hit;
  logic want_byte;
  logic busy;
  logic take;
  logic kv;

  assign in_ready = busy && !start && (!lane_hit || want_byte);
  assign take     = in_valid && in_ready;
  assign kv       = take && lane_hit;

  hdr_lane_filter #(
    .CHUNK (CHUNK),
    .N_IMG (N_IMG)
  ) u_lane (
    .clk      (clk),
    .rst      (rst),
    .restart  (start),
    .sel      (img_sel),
    .take     (take),
    .lane_hit (lane_hit)
  );

  hdr_section_walker #(
    .LIMIT (LIMIT),
    .LEN_W (LEN_W)
  ) u_walk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .want_tag  (want_tag),
    .kv        (kv),
    .kbyte     (in_data),
    .want_byte (want_byte),
    .busy      (busy),
    .done_o    (done),
    .found_o   (found),
    .err_o     (err),
    .len_o     (sec_len)
  );

endmodule

// File: rtl/cfg_hdr_walker_chk.sv
module cfg_hdr_walker_chk #(
  parameter int LEN_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             in_ready,
  input logic             done,
  input logic             found,
  input logic             err,
  input logic [LEN_W-1:0] sec_len
);

  p_start_clears_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && !found && !err && sec_len == '0));

  p_found_clean_r7: assert property (@(posedge clk) disable iff (rst)
    found |-> (done && !err));

  p_len_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !found |-> (sec_len == '0));

  p_err_ends_r3: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  p_done_stall_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);

  p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(found) && $stable(err) && $stable(sec_len)));

endmodule

bind cfg_hdr_walker cfg_hdr_walker_chk #(.LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .in_ready (in_ready),
  .done     (done),
  .found    (found),
  .err      (err),
  .sec_len  (sec_len)
);

// File: tb/cfg_hdr_walker_tb.sv
module cfg_hdr_walker_tb;

  localparam int CLK_NS = 10;
  localparam int CHUNK  = 288;
  localparam int N_IMG  = 3;
  localparam int LIMIT  = 100;
  localparam int LEN_W  = 32;
  localparam int SLEN   = CHUNK * N_IMG;
  localparam int NV     = 13;

  // {sel[63:62], scen[61:58], want[57:50], kept[49:34], found[33], err[32], len[31:0]}
  localparam logic [63:0] VEC [NV] = '{
    {2'd0, 4'd0, 8'h61, 16'd16,  1'b1, 1'b0, 32'd5},
    {2'd1, 4'd0, 8'h63, 16'd30,  1'b1, 1'b0, 32'd2},
    {2'd2, 4'd0, 8'h65, 16'd44,  1'b1, 1'b0, 32'h01002345},
    {2'd0, 4'd0, 8'h64, 16'd35,  1'b1, 1'b0, 32'd4},
    {2'd1, 4'd0, 8'h66, 16'd113, 1'b0, 1'b0, 32'd0},
    {2'd2, 4'd1, 8'h61, 16'd6,   1'b0, 1'b1, 32'd0},
    {2'd0, 4'd2, 8'h62, 16'd18,  1'b0, 1'b0, 32'd0},
    {2'd1, 4'd3, 8'h62, 16'd16,  1'b0, 1'b1, 32'd0},
    {2'd2, 4'd3, 8'h65, 16'd16,  1'b0, 1'b1, 32'd0},
    {2'd0, 4'd4, 8'h62, 16'd113, 1'b0, 1'b0, 32'd0},
    {2'd2, 4'd5, 8'h62, 16'd112, 1'b1, 1'b0, 32'd7},
    {2'd1, 4'd6, 8'h62, 16'd113, 1'b0, 1'b0, 32'd0},
    {2'd0, 4'd7, 8'h63, 16'd19,  1'b1, 1'b0, 32'd9}
  };

  localparam logic [7:0] PRE_B [13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0,
                                         8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [1:0]       img_sel = '0;
  logic [7:0]       want_tag = '0;
  logic [7:0]       in_data = '0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic             done;
  logic             found;
  logic             err;
  logic [LEN_W-1:0] sec_len;

  logic [7:0] lane_mem [CHUNK];
  logic [7:0] stream   [SLEN];
  int         wp;
  int         pos;
  int         n_chk = 0;
  int         n_bad = 0;
  int         cyc = 0;
  bit         ended = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  cfg_hdr_walker #(
    .CHUNK (CHUNK),
    .N_IMG (N_IMG),
    .LIMIT (LIMIT),
    .LEN_W (LEN_W)
  ) u_dut (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .img_sel  (img_sel),
    .want_tag (want_tag),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .done     (done),
    .found    (found),
    .err      (err),
    .sec_len  (sec_len)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  task automatic put(input logic [7:0] b);
    lane_mem[wp] = b;
    wp++;
  endtask

  task automatic put_pre();
    for (int i = 0; i < 13; i++) put(PRE_B[i]);
  endtask

  task automatic put_sec(input logic [7:0] t, input int n);
    put(t);
    put(8'(n >> 8));
    put(8'(n));
    for (int i = 0; i < n; i++) put(8'h5C);
  endtask

  task automatic build(input int scen);
    for (int i = 0; i < CHUNK; i++) lane_mem[i] = 8'h5C;
    wp = 0;
    put_pre();
    case (scen)
      0: begin
        put_sec(8'h61, 5); put_sec(8'h62, 3); put_sec(8'h63, 2); put_sec(8'h64, 4);
        put(8'h65); put(8'h01); put(8'h00); put(8'h23); put(8'h45);
      end
      1: lane_mem[5] = 8'h0E;
      2: begin put_sec(8'h61, 1); put(8'h7A); end
      3: begin put(8'h62); put(8'h01); put(8'h00); end
      4: begin put(8'h61); put(8'h00); put(8'hC8); end
      5: begin for (int k = 0; k < 4; k++) put_sec(8'h61, 21); put_sec(8'h62, 7); end
      6: begin for (int k = 0; k < 4; k++) put_sec(8'h61, 22); put_sec(8'h62, 7); end
      default: begin put_sec(8'h61, 0); put_sec(8'h63, 9); end
    endcase
  endtask

  // R2 layout: raw byte i belongs to image (i / CHUNK) mod N_IMG
  task automatic weave(input int sel);
    for (int i = 0; i < SLEN; i++)
      stream[i] = (((i / CHUNK) % N_IMG) == sel) ? lane_mem[i % CHUNK] : 8'hAA;
  endtask

  function automatic int raw_used(input int sel, input int kept);
    int j;
    if (kept == 0) return 0;
    j = kept - 1;
    return ((j / CHUNK) * N_IMG + sel) * CHUNK + (j % CHUNK) + 1;
  endfunction

  task automatic pulse_start(input int sel, input logic [7:0] want);
    @(negedge clk);
    start    = 1'b1;
    in_valid = 1'b0;
    img_sel  = 2'(sel);
    want_tag = want;
    @(negedge clk);
    start = 1'b0;
    pos   = 0;
  endtask

  task automatic feed(input int max_cyc);
    for (int c = 0; c < max_cyc; c++) begin
      @(negedge clk);
      if (done) break;
      if (pos < SLEN) begin
        in_valid = 1'b1;
        in_data  = stream[pos];
        if (in_ready) pos++;
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  function automatic string req_of(input int scen, input logic f);
    case (scen)
      1: return "R3";
      2: return "R4";
      3: return "R6";
      4: return "R9";
      5: return "R9";
      6: return "R9";
      7: return "R8";
      default: return f ? "R7" : "R9";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready after reset", 64'(in_ready), 64'd0);
    chk("R1 done after reset", 64'({done, found, err}), 64'd0);
    chk("R1 len after reset", 64'(sec_len), 64'd0);

    for (int v = 0; v < NV; v++) begin
      int   sel, scen, kept;
      logic [7:0] want;
      string rq;
      sel  = int'(VEC[v][63:62]);
      scen = int'(VEC[v][61:58]);
      want = VEC[v][57:50];
      kept = int'(VEC[v][49:34]);
      rq   = req_of(scen, VEC[v][33]);
      build(scen);
      weave(sel);
      pulse_start(sel, want);
      feed(3000);
      chk({rq, " done"}, 64'(done), 64'd1);
      chk({rq, " found"}, 64'(found), 64'(VEC[v][33]));
      chk({rq, " err"}, 64'(err), 64'(VEC[v][32]));
      chk({rq, " R5 len"}, 64'(sec_len), 64'(VEC[v][31:0]));
      chk({rq, " R2 raw bytes consumed"}, 64'(pos), 64'(raw_used(sel, kept)));
    end

    // R10: stall and hold after done while a byte is offered
    in_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10 ready low while done", 64'(in_ready), 64'd0);
      chk("R10 outputs hold", 64'({done, found, err, sec_len}), {29'd0, 3'b110, 32'd9});
    end

    // R1: start clears a finished result
    build(0);
    weave(1);
    pulse_start(1, 8'h63);
    chk("R1 cleared after start", 64'({done, found, err, sec_len}), 64'd0);
    // R1 latching: inputs changed after start must not matter
    img_sel  = 2'd0;
    want_tag = 8'h61;
    feed(3000);
    chk("R1 latched tag found", 64'({found, sec_len}), {31'd0, 1'b1, 32'd2});
    chk("R1 latched sel consumed", 64'(pos), 64'(raw_used(1, 30)));

    // R1 restart during a parse
    build(0);
    weave(0);
    pulse_start(0, 8'h65);
    feed(20);
    chk("R1 busy mid parse", 64'(done), 64'd0);
    pulse_start(0, 8'h61);
    feed(3000);
    chk("R1 restart result", 64'({found, err, sec_len}), {30'd0, 2'b10, 32'd5});
    chk("R1 restart consumed", 64'(pos), 64'(raw_used(0, 16)));

    finish_run();
  end

endmodule